// File: doc/BRIEF.md
# Low-Power Counter Register Interface

This block is the register front end of a low-power counter. A simple single-cycle register bus reaches seven word locations. Through them software enables the counter and starts it, sets its operating mode and loads its reload and compare values. Software also watches two acknowledge flags and reads back the live count. The counting core itself sits outside. It receives the enable, run, mode and value outputs, and it returns its count on an input port.

The block enforces a fixed ordering. The mode word can change only while the block is disabled. The reload and compare values accept writes only while it is enabled. A start request counts only when the block was already enabled. A reload or compare write does not act at once. It passes through a short synchronisation delay. When the new value reaches the core, a sticky OK flag is raised. Software clears that flag by writing ones to a separate clear location. Every write merges the data with a per-bit write mask, so only the masked bits change.

Top module: `lpc_regif`

## Requirements
- R1: After reset, CTRL (0) reads 0, CFG (1) reads 0, RELOAD (2) reads all ones, CMP (3) reads 0 and STAT (4) reads 0. The outputs core_en and core_run are 0.
- R2: CTRL holds the enable in bit 0, the start request in bit 1 and the read-only run state in bit 2. A start written while enable is already 1 reads back as bit 1 for one cycle. After that, bit 1 reads 0 and bit 2 reads 1. A start written while enable is 0 is discarded.
- R3: Writing 0 to CTRL bit 0 clears the enable, the run state and any pending start in the same cycle. core_run is never 1 while core_en is 0.
- R4: A CFG write while enable is 0 replaces only the bits set in bus_wmask. The CFG layout is bit 0 encoder mode, bit 1 external count, bits 3:2 edge polarity and bits from 4 up the prescaler. A CFG write while enable is 1 is ignored.
- R5: A write to RELOAD or CMP while enable is 0 changes neither the value nor any flag.
- R6: A RELOAD or CMP write accepted in cycle k makes the new value visible, both on the read-back and on the output port, at the clock edge two cycles later. At that same edge the block sets STAT bit 1 (reload OK) or STAT bit 0 (compare OK).
- R7: A second write to the same register before its flag is set restarts the two-cycle delay, and the later value wins.
- R8: A write of ones to CLR (5) clears the matching STAT flags. A flag whose bit is written as 0 stays as it is. A flag being set in the same cycle stays set.
- R9: COUNT (6) reads the core_count input. Writes to COUNT, and to STAT, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word location |
| bus_wdata | input | DATA_W | Write data |
| bus_wmask | input | DATA_W | Per-bit write mask |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not reading |
| core_count | input | CNT_W | Live count from the counting core |
| core_en | output | 1 | Peripheral enable |
| core_run | output | 1 | Counter running continuously |
| cfg_enc | output | 1 | Encoder mode |
| cfg_ext | output | 1 | External count mode |
| cfg_pol | output | 2 | Edge polarity select |
| cfg_presc | output | PRESC_W | Prescaler select |
| reload_value | output | CNT_W | Active reload value |
| compare_value | output | CNT_W | Active compare value |

## Verification
The checker watches four rules on every cycle:
- the run state never outlives the enable;
- a run only begins after an enabled cycle;
- the mode word stays frozen while the block is enabled;
- a reload value, or an OK flag, changes only on a completion event, and a clear without a coincident completion drops its flag.

Other behaviour shows only in the bench's scenarios. These are the exact two-cycle latency, the restart on a second write, the masked merges, the discarded start and the set-over-clear priority. Each needs a timed sequence of bus writes followed by reads.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [2:0] {
    LOC_CTRL   = 3'd0,
    LOC_CFG    = 3'd1,
    LOC_RELOAD = 3'd2,
    LOC_CMP    = 3'd3,
    LOC_STAT   = 3'd4,
    LOC_CLR    = 3'd5,
    LOC_COUNT  = 3'd6
  } lpc_loc_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int CTRL_RUN_BIT   = 2;

  localparam int CFG_ENC_BIT   = 0;
  localparam int CFG_EXT_BIT   = 1;
  localparam int CFG_POL_LSB   = 2;
  localparam int CFG_PRESC_LSB = 4;

  // index into the acknowledge channels, equal to the STAT/CLR bit
  localparam int ACK_CMP    = 0;
  localparam int ACK_RELOAD = 1;
  localparam int ACK_N      = 2;

endpackage

// File: rtl/lpc_ack_sync.sv
// One write-acknowledge channel: stages a value, delivers it after DELAY
// cycles and raises a sticky OK flag at the same edge.
module lpc_ack_sync #(
  parameter int W = 16,
  parameter int DELAY = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  input  logic         clr_fire,
  output logic [W-1:0] value,
  output logic         ok,
  output logic         done
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] wait_cnt;
  logic [W-1:0]  staged;

  // completion when the last wait cycle elapses and no new write restarts it
  assign done = (wait_cnt == CW'(1)) && !wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      staged   <= RST_VAL;
      value    <= RST_VAL;
      ok       <= 1'b0;
    end else begin
      if (wr_fire) begin
        wait_cnt <= CW'(DELAY);
        staged   <= wr_data;
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - CW'(1);
      end
      if (done) begin
        value <= staged;
        ok    <= 1'b1;
      end else if (clr_fire) begin
        ok <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lpc_ctrl.sv
// Enable, pending start and run state with their ordering rules.
module lpc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic en_next,
  input  logic start_req,
  output logic en,
  output logic start_pend,
  output logic run
);
  logic start_ok;
  assign start_ok = wr_ctrl && en && en_next && start_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      start_pend <= 1'b0;
      run        <= 1'b0;
    end else if (wr_ctrl && !en_next) begin
      en         <= 1'b0;
      start_pend <= 1'b0;
      run        <= 1'b0;
    end else begin
      if (wr_ctrl) en <= 1'b1;
      if (start_pend) begin
        run        <= 1'b1;
        start_pend <= 1'b0;
      end else if (start_ok) begin
        start_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpc_cfg.sv
// Mode word, written with a bit mask and locked while enabled.
module lpc_cfg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_cfg,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] cfg
);
  function automatic logic [W-1:0] blend(input logic [W-1:0] old_v,
                                         input logic [W-1:0] new_v,
                                         input logic [W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg <= '0;
    else if (wr_cfg && !locked) cfg <= blend(cfg, wdata, wmask);
  end
endmodule

// File: rtl/lpc_regif.sv
module lpc_regif #(
  parameter int DATA_W = 16,
  parameter int CNT_W = 16,
  parameter int PRESC_W = 3,
  parameter int SYNC_DELAY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_wmask,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]   core_count,
  output logic               core_en,
  output logic               core_run,
  output logic               cfg_enc,
  output logic               cfg_ext,
  output logic [1:0]         cfg_pol,
  output logic [PRESC_W-1:0] cfg_presc,
  output logic [CNT_W-1:0]   reload_value,
  output logic [CNT_W-1:0]   compare_value
);
  import lpc_pkg::*;

  localparam int CFG_W = CFG_PRESC_LSB + PRESC_W;

  function automatic logic [CNT_W-1:0] merge_val(input logic [CNT_W-1:0] old_v,
                                                 input logic [CNT_W-1:0] new_v,
                                                 input logic [CNT_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  lpc_loc_e loc;
  logic     wr_any, rd_any;
  assign loc    = lpc_loc_e'(bus_addr);
  assign wr_any = bus_sel && bus_wr;
  assign rd_any = bus_sel && !bus_wr;

  // named events for the checker
  logic             wr_ctrl, wr_cfg;
  logic             start_pend;
  logic [CFG_W-1:0] cfg_word;
  logic [ACK_N-1:0] ack_wr, ack_clr, ack_ok, ack_done;
  logic [CNT_W-1:0] ack_val [ACK_N];
  logic [CNT_W-1:0] ack_data [ACK_N];

  assign wr_ctrl = wr_any && (loc == LOC_CTRL);
  assign wr_cfg  = wr_any && (loc == LOC_CFG);

  lpc_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .en_next    ((bus_wdata[CTRL_EN_BIT] & bus_wmask[CTRL_EN_BIT]) |
                 (core_en & ~bus_wmask[CTRL_EN_BIT])),
    .start_req  (bus_wdata[CTRL_START_BIT] & bus_wmask[CTRL_START_BIT]),
    .en         (core_en),
    .start_pend (start_pend),
    .run        (core_run)
  );

  lpc_cfg #(.W(CFG_W)) cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cfg (wr_cfg),
    .locked (core_en),
    .wdata  (bus_wdata[CFG_W-1:0]),
    .wmask  (bus_wmask[CFG_W-1:0]),
    .cfg    (cfg_word)
  );

  assign cfg_enc   = cfg_word[CFG_ENC_BIT];
  assign cfg_ext   = cfg_word[CFG_EXT_BIT];
  assign cfg_pol   = cfg_word[CFG_POL_LSB +: 2];
  assign cfg_presc = cfg_word[CFG_PRESC_LSB +: PRESC_W];

  for (genvar g = 0; g < ACK_N; g++) begin : g_ack
    localparam lpc_loc_e MY_LOC = (g == ACK_RELOAD) ? LOC_RELOAD : LOC_CMP;
    localparam logic [CNT_W-1:0] MY_RST = (g == ACK_RELOAD) ? '1 : '0;

    assign ack_wr[g]   = wr_any && (loc == MY_LOC) && core_en;
    assign ack_clr[g]  = wr_any && (loc == LOC_CLR) && bus_wdata[g] && bus_wmask[g];
    assign ack_data[g] = merge_val(ack_val[g], bus_wdata[CNT_W-1:0], bus_wmask[CNT_W-1:0]);

    lpc_ack_sync #(.W(CNT_W), .DELAY(SYNC_DELAY), .RST_VAL(MY_RST)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_fire  (ack_wr[g]),
      .wr_data  (ack_data[g]),
      .clr_fire (ack_clr[g]),
      .value    (ack_val[g]),
      .ok       (ack_ok[g]),
      .done     (ack_done[g])
    );
  end

  assign reload_value  = ack_val[ACK_RELOAD];
  assign compare_value = ack_val[ACK_CMP];

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (loc)
        LOC_CTRL: begin
          bus_rdata[CTRL_EN_BIT]    = core_en;
          bus_rdata[CTRL_START_BIT] = start_pend;
          bus_rdata[CTRL_RUN_BIT]   = core_run;
        end
        LOC_CFG:    bus_rdata = DATA_W'(cfg_word);
        LOC_RELOAD: bus_rdata = DATA_W'(reload_value);
        LOC_CMP:    bus_rdata = DATA_W'(compare_value);
        LOC_STAT:   bus_rdata = DATA_W'(ack_ok);
        LOC_COUNT:  bus_rdata = DATA_W'(core_count);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lpc_regif_chk.sv
module lpc_regif_chk #(
  parameter int CNT_W = 16,
  parameter int CFG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_en,
  input logic             core_run,
  input logic [CFG_W-1:0] cfg_word,
  input logic [CNT_W-1:0] reload_value,
  input logic [1:0]       ack_done,
  input logic [1:0]       ack_ok,
  input logic [1:0]       ack_clr
);
  assert_run_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> core_en);

  assert_run_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(core_en));

  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> $stable(cfg_word));

  assert_reload_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_done[1] |=> $stable(reload_value));

  assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_ok[1]) |-> $past(ack_done[1]));

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr[0] && !ack_done[0]) |=> !ack_ok[0]);
endmodule

bind lpc_regif lpc_regif_chk #(
  .CNT_W(CNT_W),
  .CFG_W(CFG_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_en      (core_en),
  .core_run     (core_run),
  .cfg_word     (cfg_word),
  .reload_value (reload_value),
  .ack_done     (ack_done),
  .ack_ok       (ack_ok),
  .ack_clr      (ack_clr)
);

// File: tb/lpc_regif_tb.sv
module lpc_regif_tb_top;
  localparam int DW = 16;
  localparam logic [1:0] OP_N = 2'd0, OP_W = 2'd1, OP_R = 2'd2;
  localparam logic [DW-1:0] CNT_IN = 16'h2A5A;
  localparam int NV = 49;

  // {req, op, addr, data, mask, expected}
  localparam logic [56:0] VEC [NV] = '{
    {4'd1, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0000}, // R1 ctrl
    {4'd1, OP_R, 3'd1, 16'h0000, 16'h0000, 16'h0000}, // R1 cfg
    {4'd1, OP_R, 3'd2, 16'h0000, 16'h0000, 16'hFFFF}, // R1 reload
    {4'd1, OP_R, 3'd3, 16'h0000, 16'h0000, 16'h0000}, // R1 cmp
    {4'd1, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000}, // R1 stat
    {4'd5, OP_W, 3'd2, 16'h1234, 16'hFFFF, 16'h0000}, // R5 reload while disabled
    {4'd5, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000},
    {4'd5, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000},
    {4'd5, OP_R, 3'd2, 16'h0000, 16'h0000, 16'hFFFF},
    {4'd4, OP_W, 3'd1, 16'h007F, 16'h000F, 16'h0000}, // R4 masked low
    {4'd4, OP_R, 3'd1, 16'h0000, 16'h0000, 16'h000F},
    {4'd4, OP_W, 3'd1, 16'h0050, 16'h0070, 16'h0000}, // R4 masked prescaler
    {4'd4, OP_R, 3'd1, 16'h0000, 16'h0000, 16'h005F},
    {4'd2, OP_W, 3'd0, 16'h0001, 16'hFFFF, 16'h0000}, // enable
    {4'd4, OP_W, 3'd1, 16'h0000, 16'hFFFF, 16'h0000}, // R4 locked
    {4'd4, OP_R, 3'd1, 16'h0000, 16'h0000, 16'h005F},
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0001},
    {4'd6, OP_W, 3'd2, 16'h0100, 16'hFFFF, 16'h0000}, // R6 reload
    {4'd6, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000},
    {4'd6, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000},
    {4'd6, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0002},
    {4'd6, OP_R, 3'd2, 16'h0000, 16'h0000, 16'h0100},
    {4'd7, OP_W, 3'd3, 16'h0040, 16'hFFFF, 16'h0000}, // R7 cmp twice
    {4'd7, OP_W, 3'd3, 16'h0041, 16'hFFFF, 16'h0000},
    {4'd7, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0002},
    {4'd7, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0002},
    {4'd7, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0003},
    {4'd7, OP_R, 3'd3, 16'h0000, 16'h0000, 16'h0041},
    {4'd8, OP_W, 3'd5, 16'h0002, 16'hFFFF, 16'h0000}, // R8 clear reload ok
    {4'd8, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0001},
    {4'd8, OP_W, 3'd5, 16'h0001, 16'hFFFF, 16'h0000},
    {4'd8, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0000},
    {4'd9, OP_W, 3'd6, 16'hFFFF, 16'hFFFF, 16'h0000}, // R9 count write
    {4'd9, OP_R, 3'd6, 16'h0000, 16'h0000, CNT_IN},
    {4'd2, OP_W, 3'd0, 16'h0003, 16'hFFFF, 16'h0000}, // R2 start
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0003},
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0005},
    {4'd3, OP_W, 3'd0, 16'h0000, 16'hFFFF, 16'h0000}, // R3 disable
    {4'd3, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0000},
    {4'd2, OP_W, 3'd0, 16'h0002, 16'hFFFF, 16'h0000}, // R2 start while off
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0000},
    {4'd2, OP_N, 3'd0, 16'h0000, 16'h0000, 16'h0000},
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0000},
    {4'd2, OP_W, 3'd0, 16'h0003, 16'hFFFF, 16'h0000}, // R2 enable+start together
    {4'd2, OP_R, 3'd0, 16'h0000, 16'h0000, 16'h0001},
    {4'd8, OP_W, 3'd2, 16'h0200, 16'hFFFF, 16'h0000}, // R8 set beats clear
    {4'd8, OP_N, 3'd0, 16'h0000, 16'h0000, 16'h0000},
    {4'd8, OP_W, 3'd5, 16'h0002, 16'hFFFF, 16'h0000},
    {4'd8, OP_R, 3'd4, 16'h0000, 16'h0000, 16'h0002}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_wmask = '0, bus_rdata;
  logic core_en, core_run, cfg_enc, cfg_ext;
  logic [1:0] cfg_pol;
  logic [2:0] cfg_presc;
  logic [DW-1:0] reload_value, compare_value;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lpc_regif dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .core_count(CNT_IN), .core_en(core_en),
    .core_run(core_run), .cfg_enc(cfg_enc), .cfg_ext(cfg_ext),
    .cfg_pol(cfg_pol), .cfg_presc(cfg_presc), .reload_value(reload_value),
    .compare_value(compare_value)
  );

  task automatic check(input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] op, input logic [2:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] m);
    @(negedge clk);
    bus_sel   = (op != OP_N);
    bus_wr    = (op == OP_W);
    bus_addr  = a;
    bus_wdata = d;
    bus_wmask = m;
    #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][52:51], VEC[i][50:48], VEC[i][47:32], VEC[i][31:16]);
      if (VEC[i][52:51] == OP_R)
        check(int'(VEC[i][56:53]), $sformatf("vector %0d", i), bus_rdata, VEC[i][15:0]);
    end
    bus_op(OP_N, 3'd0, '0, '0);
    // R4 mode fields on the ports: cfg = 0x5F
    check(4, "cfg_enc", DW'(cfg_enc), 16'd1);
    check(4, "cfg_ext", DW'(cfg_ext), 16'd1);
    check(4, "cfg_pol", DW'(cfg_pol), 16'd3);
    check(4, "cfg_presc", DW'(cfg_presc), 16'd5);
    // R6 values delivered to the core
    check(6, "reload_value", reload_value, 16'h0200);
    check(6, "compare_value", compare_value, 16'h0041);
    // R2 start from enabled state drives core_run
    check(2, "core_run idle", DW'(core_run), 16'd0);
    bus_op(OP_W, 3'd0, 16'h0003, 16'hFFFF);
    bus_op(OP_N, 3'd0, '0, '0);
    check(2, "core_run pending", DW'(core_run), 16'd0);
    bus_op(OP_N, 3'd0, '0, '0);
    check(2, "core_run up", DW'(core_run), 16'd1);
    // R3 masked-out enable bit leaves counter running; then stop
    bus_op(OP_W, 3'd0, 16'h0000, 16'hFFFE);
    bus_op(OP_N, 3'd0, '0, '0);
    check(3, "core_run masked", DW'(core_run), 16'd1);
    bus_op(OP_W, 3'd0, 16'h0000, 16'h0001);
    bus_op(OP_N, 3'd0, '0, '0);
    check(3, "core_run stop", DW'(core_run), 16'd0);
    check(3, "core_en stop", DW'(core_en), 16'd0);
    // R1 reset in the middle of operation
    rst_n = 1'b0;
    #1;
    check(1, "reset core_en", DW'(core_en), 16'd0);
    check(1, "reset reload", reload_value, 16'hFFFF);
    check(1, "reset compare", compare_value, 16'h0000);
    check(1, "reset cfg_pol", DW'(cfg_pol), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    bus_op(OP_R, 3'd4, '0, '0);
    check(1, "reset stat", bus_rdata, 16'h0000);
    bus_op(OP_N, 3'd0, '0, '0);
    finish_run();
  end
endmodule